// File: doc/BRIEF.md
# Fan Stall and Drive-Fail Monitor

This block watches a single fan. Each cycle it sees the fan's measured tachometer period count, the current drive level and the control settings. It raises two sticky status flags. The stall flag means the measured count has gone above the largest count still accepted as a spinning fan. The drive-fail flag means the fan cannot come close enough to its target count even at full drive. An active-low alert follows the two flags. In closed-loop operation the block also asks the speed controller to restart a stalled fan, once per control update, until the fan reports a valid count again.

A larger count means a slower fan. The stall check depends on the operating mode. In direct drive mode it runs on every cycle. In closed-loop mode it runs only on the update strobe, which marks the moment the controller refreshes its drive value. A spin-up window blocks new stall reports while the fan accelerates. This window is a down-counter that the spin-up start pulse loads from the spin-up time input.

The stall tracker is a three-state machine. `ST_OK` means no stall. `ST_RETRY` means stalled, with restart requests being issued. `ST_HELD` means stalled, with no restart requests. The transitions are:
- detect-direct: from `ST_OK` to `ST_HELD`.
- detect-loop: from `ST_OK` to `ST_RETRY`.
- recover: from `ST_RETRY` to `ST_HELD`, when a strobe sees a valid count.
- leave-loop: from `ST_RETRY` to `ST_HELD`, when the mode switches to direct.
- relapse: from `ST_HELD` to `ST_RETRY`, when a closed-loop strobe sees an invalid count.
- clear: from any stalled state back to `ST_OK`.

The drive-fail tracker has two states. It moves from `DF_WATCH` to `DF_FAILED` (trip) and from `DF_FAILED` back to `DF_WATCH` (clear).

Top module: `fan_guard`

## Requirements
- R1: In direct mode (`mode_loop` = 0), with no spin-up window running, a cycle where `tach_cnt` > `tach_limit` sets `stall_flag` on the next clock edge.
- R2: In closed-loop mode (`mode_loop` = 1), `stall_flag` can only become set at the edge where `upd_stb` = 1 and `tach_cnt` > `tach_limit`. A bad count held between strobes never sets it.
- R3: A `spin_start` pulse loads the window counter with `spin_time`. The counter then counts down by one each cycle. While it is non-zero, no new stall is reported and the alert stays high. If `spin_time` is zero, there is no window at all.
- R4: `restart_req` is a one-cycle pulse in the cycle after an update strobe taken in closed-loop mode. It fires when that strobe finds a stall, or when the fan is already stalled and its count is still above the limit.
- R5: Restart pulses stop when a strobe sees `tach_cnt` <= `tach_limit`, or when the mode switches to direct. `stall_flag` stays set in both cases.
- R6: Full drive means `drive` is all ones. `dfail_flag` sets on the FAIL_RUN-th consecutive update strobe (default 3) that finds full drive and `tach_cnt` > `target_cnt` + `band`. A strobe that does not meet this condition resets the run. Once the run reaches its limit it holds there.
- R7: `alert_n` is low exactly when `stall_flag` or `dfail_flag` is set.
- R8: Both flags are sticky. A `clr_stb` cycle clears them. If the condition that sets a flag is present in that same cycle, the set wins.
- R9: After reset both flags are low, `alert_n` is high, `restart_req` is low and no spin-up window is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_cnt | input | TACH_W | Measured tach period count |
| tach_limit | input | TACH_W | Largest count accepted as spinning |
| target_cnt | input | TACH_W | Target tach count |
| band | input | TACH_W | Allowed excess over the target count |
| drive | input | DRV_W | Current drive level; all ones means full drive |
| mode_loop | input | 1 | 1 = closed-loop mode, 0 = direct mode |
| spin_start | input | 1 | Starts the spin-up window |
| spin_time | input | SPIN_W | Window length in cycles |
| upd_stb | input | 1 | Control update strobe |
| clr_stb | input | 1 | Clears both status flags |
| stall_flag | output | 1 | Sticky stall status |
| dfail_flag | output | 1 | Sticky drive-fail status |
| alert_n | output | 1 | Active-low alert |
| restart_req | output | 1 | One-cycle restart request |

## Verification
The assertions assume the following about the inputs:
- `upd_stb`, `clr_stb` and `spin_start` are synchronous single-cycle pulses.
- The limit, target and band inputs are held steady between changes and are not chosen to create corner cases at the edge where they change.
- Full drive is encoded as all ones.

The stimulus stays within these limits. It changes every input on the falling edge and holds each level for at least one whole cycle. It raises each strobe for exactly one cycle. It never starts a spin-up window in the same cycle as a strobe.

// File: rtl/fan_guard_pkg.sv
package fan_guard_pkg;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_RETRY = 2'd1,
        ST_HELD  = 2'd2
    } stall_st_e;

    typedef enum logic {
        DF_WATCH  = 1'b0,
        DF_FAILED = 1'b1
    } dfail_st_e;

endpackage

// File: rtl/fan_spin_mask.sv
module fan_spin_mask #(
    parameter int SPIN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spin_start,
    input  logic [SPIN_W-1:0] spin_time,
    output logic              mask_busy
);

    logic [SPIN_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (spin_start) begin
            left_q <= spin_time;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign mask_busy = (left_q != '0);

endmodule

// File: rtl/fan_stall_fsm.sv
module fan_stall_fsm
    import fan_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_loop,
    input  logic upd_stb,
    input  logic clr_stb,
    input  logic masked,
    input  logic tach_bad,
    output logic stall_flag,
    output logic restart_req
);

    stall_st_e st_q, st_d, from_ok;
    logic      restart_q;

    // where the tracker goes when no stall is held yet
    always_comb begin
        if (!mode_loop && tach_bad && !masked) begin
            from_ok = ST_HELD;
        end else if (mode_loop && upd_stb && tach_bad && !masked) begin
            from_ok = ST_RETRY;
        end else begin
            from_ok = ST_OK;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OK: begin
                st_d = from_ok;
            end
            ST_RETRY: begin
                if (clr_stb) begin
                    st_d = from_ok;
                end else if (!mode_loop) begin
                    st_d = ST_HELD;
                end else if (upd_stb && !tach_bad) begin
                    st_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (clr_stb) begin
                    st_d = from_ok;
                end else if (mode_loop && upd_stb && tach_bad) begin
                    st_d = ST_RETRY;
                end
            end
            default: begin
                st_d = ST_OK;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OK;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
        end else begin
            restart_q <= mode_loop && upd_stb && (st_d == ST_RETRY);
        end
    end

    always_comb begin
        stall_flag  = (st_q != ST_OK);
        restart_req = restart_q;
    end

endmodule

// File: rtl/fan_dfail_det.sv
module fan_dfail_det
    import fan_guard_pkg::*;
#(
    parameter int TACH_W   = 16,
    parameter int DRV_W    = 8,
    parameter int FAIL_RUN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TACH_W-1:0] tach_cnt,
    input  logic [TACH_W-1:0] target_cnt,
    input  logic [TACH_W-1:0] band,
    input  logic [DRV_W-1:0]  drive,
    input  logic              upd_stb,
    input  logic              clr_stb,
    output logic              dfail_flag
);

    localparam int RUN_W = $clog2(FAIL_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FAIL_RUN - 1);

    dfail_st_e        st_q, st_d;
    logic [RUN_W-1:0] run_q;
    logic [TACH_W:0]  ceiling;
    logic             over, hit;

    assign ceiling = {1'b0, target_cnt} + {1'b0, band};
    assign over    = (&drive) && ({1'b0, tach_cnt} > ceiling);
    assign hit     = upd_stb && over && (run_q == RUN_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (upd_stb) begin
            if (!over) begin
                run_q <= '0;
            end else if (run_q != RUN_LAST) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DF_WATCH:  st_d = hit ? DF_FAILED : DF_WATCH;
            DF_FAILED: st_d = (clr_stb && !hit) ? DF_WATCH : DF_FAILED;
            default:   st_d = DF_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DF_WATCH;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        dfail_flag = (st_q == DF_FAILED);
    end

endmodule

// File: rtl/fan_guard.sv
module fan_guard #(
    parameter int TACH_W   = 16,
    parameter int DRV_W    = 8,
    parameter int SPIN_W   = 8,
    parameter int FAIL_RUN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TACH_W-1:0] tach_cnt,
    input  logic [TACH_W-1:0] tach_limit,
    input  logic [TACH_W-1:0] target_cnt,
    input  logic [TACH_W-1:0] band,
    input  logic [DRV_W-1:0]  drive,
    input  logic              mode_loop,
    input  logic              spin_start,
    input  logic [SPIN_W-1:0] spin_time,
    input  logic              upd_stb,
    input  logic              clr_stb,
    output logic              stall_flag,
    output logic              dfail_flag,
    output logic              alert_n,
    output logic              restart_req
);

    logic mask_busy;
    logic tach_bad;

    assign tach_bad = (tach_cnt > tach_limit);

    fan_spin_mask #(.SPIN_W(SPIN_W)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .spin_start (spin_start),
        .spin_time  (spin_time),
        .mask_busy  (mask_busy)
    );

    fan_stall_fsm u_stall (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_loop   (mode_loop),
        .upd_stb     (upd_stb),
        .clr_stb     (clr_stb),
        .masked      (mask_busy),
        .tach_bad    (tach_bad),
        .stall_flag  (stall_flag),
        .restart_req (restart_req)
    );

    fan_dfail_det #(
        .TACH_W   (TACH_W),
        .DRV_W    (DRV_W),
        .FAIL_RUN (FAIL_RUN)
    ) u_dfail (
        .clk        (clk),
        .rst_n      (rst_n),
        .tach_cnt   (tach_cnt),
        .target_cnt (target_cnt),
        .band       (band),
        .drive      (drive),
        .upd_stb    (upd_stb),
        .clr_stb    (clr_stb),
        .dfail_flag (dfail_flag)
    );

    assign alert_n = ~(stall_flag | dfail_flag);

endmodule

// File: rtl/fan_guard_chk.sv
module fan_guard_chk #(
    parameter int TACH_W = 16,
    parameter int DRV_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_loop,
    input logic              upd_stb,
    input logic              clr_stb,
    input logic [TACH_W-1:0] tach_cnt,
    input logic [TACH_W-1:0] tach_limit,
    input logic [DRV_W-1:0]  drive,
    input logic              mask_busy,
    input logic              stall_flag,
    input logic              dfail_flag,
    input logic              restart_req
);

    // R1
    direct_stall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_flag && !mode_loop && !mask_busy && (tach_cnt > tach_limit)) |=> stall_flag);

    // R2
    loop_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_flag && mode_loop && !upd_stb) |=> !stall_flag);

    // R3
    spin_window_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_flag && mask_busy) |=> !stall_flag);

    // R4
    restart_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> ($past(upd_stb) && $past(mode_loop)));

    // R6
    dfail_needs_full_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dfail_flag && !(upd_stb && (&drive))) |=> !dfail_flag);

    // R8
    stall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_flag && !clr_stb) |=> stall_flag);

    // R8
    dfail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dfail_flag && !clr_stb) |=> dfail_flag);

endmodule

bind fan_guard fan_guard_chk #(
    .TACH_W (TACH_W),
    .DRV_W  (DRV_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_loop   (mode_loop),
    .upd_stb     (upd_stb),
    .clr_stb     (clr_stb),
    .tach_cnt    (tach_cnt),
    .tach_limit  (tach_limit),
    .drive       (drive),
    .mask_busy   (mask_busy),
    .stall_flag  (stall_flag),
    .dfail_flag  (dfail_flag),
    .restart_req (restart_req)
);

// File: tb/sim_fan_guard.sv
`timescale 1ns/1ps
module sim_fan_guard;

    localparam int TACH_W   = 16;
    localparam int DRV_W    = 8;
    localparam int SPIN_W   = 8;
    localparam int FAIL_RUN = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TACH_W-1:0] tach_cnt = '0;
    logic [TACH_W-1:0] tach_limit = 16'd1000;
    logic [TACH_W-1:0] target_cnt = 16'd200;
    logic [TACH_W-1:0] band = 16'd50;
    logic [DRV_W-1:0]  drive = '0;
    logic              mode_loop = 1'b0;
    logic              spin_start = 1'b0;
    logic [SPIN_W-1:0] spin_time = '0;
    logic              upd_stb = 1'b0;
    logic              clr_stb = 1'b0;
    logic              stall_flag, dfail_flag, alert_n, restart_req;

    int checks = 0;
    int errors = 0;
    bit armed = 1'b0;
    bit reported = 1'b0;

    // reference state
    int m_mask = 0;
    int m_st = 0;      // 0 none, 1 stalled+retrying, 2 stalled quiet
    int m_run = 0;
    int m_df = 0;
    int m_rst = 0;

    always #10 clk = ~clk;

    fan_guard #(
        .TACH_W(TACH_W), .DRV_W(DRV_W), .SPIN_W(SPIN_W), .FAIL_RUN(FAIL_RUN)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tach_cnt(tach_cnt), .tach_limit(tach_limit),
        .target_cnt(target_cnt), .band(band), .drive(drive), .mode_loop(mode_loop),
        .spin_start(spin_start), .spin_time(spin_time), .upd_stb(upd_stb),
        .clr_stb(clr_stb), .stall_flag(stall_flag), .dfail_flag(dfail_flag),
        .alert_n(alert_n), .restart_req(restart_req)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        int  nst, okn;
        bit  bad, masked, over, hit, full;
        if (!rst_n) begin
            m_mask = 0; m_st = 0; m_run = 0; m_df = 0; m_rst = 0;
        end else begin
            bad    = (int'(tach_cnt) > int'(tach_limit));
            masked = (m_mask != 0);
            full   = (drive == {DRV_W{1'b1}});
            over   = full && (int'(tach_cnt) > int'(target_cnt) + int'(band));
            if (!mode_loop && bad && !masked) okn = 2;
            else if (mode_loop && upd_stb && bad && !masked) okn = 1;
            else okn = 0;
            if (m_st == 0 || clr_stb) nst = okn;
            else if (m_st == 1) nst = (!mode_loop || (upd_stb && !bad)) ? 2 : 1;
            else nst = (mode_loop && upd_stb && bad) ? 1 : 2;
            m_rst = (mode_loop && upd_stb && nst == 1) ? 1 : 0;
            m_st = nst;
            hit = upd_stb && over && (m_run == FAIL_RUN - 1);
            if (hit) m_df = 1;
            else if (clr_stb) m_df = 0;
            if (upd_stb) begin
                if (!over) m_run = 0;
                else if (m_run < FAIL_RUN - 1) m_run = m_run + 1;
            end
            if (spin_start) m_mask = int'(spin_time);
            else if (m_mask != 0) m_mask = m_mask - 1;
            armed = 1'b1;
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (armed) begin
            check("R1 R2 stall_flag vs model", int'(stall_flag), (m_st != 0) ? 1 : 0);
            check("R6 dfail_flag vs model", int'(dfail_flag), m_df);
            check("R4 restart_req vs model", int'(restart_req), m_rst);
            check("R7 alert_n vs model", int'(alert_n),
                  ((m_st != 0) || (m_df != 0)) ? 0 : 1);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_upd();
        @(negedge clk) upd_stb = 1'b1;
        @(negedge clk) upd_stb = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) clr_stb = 1'b1;
        @(negedge clk) clr_stb = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R9: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        check("R9 reset stall", int'(stall_flag), 0);
        check("R9 reset dfail", int'(dfail_flag), 0);
        check("R9 reset alert_n", int'(alert_n), 1);
        check("R9 reset restart", int'(restart_req), 0);

        // direct mode
        tach_cnt = 16'd500;
        step(3);
        check("R1 good count no stall", int'(stall_flag), 0);
        tach_cnt = 16'd1500;
        step(1);
        check("R1 bad count sets stall", int'(stall_flag), 1);
        check("R7 alert on stall", int'(alert_n), 0);
        pulse_clr();
        check("R8 set wins over clear", int'(stall_flag), 1);
        tach_cnt = 16'd500;
        pulse_clr();
        check("R8 clear drops stall", int'(stall_flag), 0);
        check("R8 alert released", int'(alert_n), 1);

        // spin-up window
        spin_time = 8'd10;
        @(negedge clk) spin_start = 1'b1;
        @(negedge clk) begin spin_start = 1'b0; tach_cnt = 16'd1500; end
        for (int i = 0; i < 10; i++) begin
            check("R3 no alert inside window", int'(alert_n), 1);
            step(1);
        end
        step(3);
        check("R3 stall after window", int'(stall_flag), 1);
        tach_cnt = 16'd500;
        pulse_clr();
        spin_time = 8'd0;
        @(negedge clk) begin spin_start = 1'b1; tach_cnt = 16'd1500; end
        @(negedge clk) spin_start = 1'b0;
        check("R3 zero window no mask", int'(stall_flag), 1);
        tach_cnt = 16'd500;
        pulse_clr();

        // closed-loop mode
        mode_loop = 1'b1;
        tach_cnt = 16'd1500;
        for (int i = 0; i < 20; i++) begin
            step(1);
            check("R2 no stall between strobes", int'(stall_flag), 0);
        end
        pulse_upd();
        check("R2 stall on strobe", int'(stall_flag), 1);
        check("R4 restart on detection", int'(restart_req), 1);
        step(1);
        check("R4 restart lasts one cycle", int'(restart_req), 0);
        pulse_upd();
        check("R4 restart repeats", int'(restart_req), 1);
        tach_cnt = 16'd500;
        pulse_upd();
        check("R5 valid count stops restart", int'(restart_req), 0);
        check("R5 stall stays set", int'(stall_flag), 1);
        tach_cnt = 16'd1500;
        pulse_upd();
        check("R4 relapse restarts", int'(restart_req), 1);
        @(negedge clk) mode_loop = 1'b0;
        pulse_upd();
        check("R5 direct mode no restart", int'(restart_req), 0);
        check("R5 stall kept in direct", int'(stall_flag), 1);
        tach_cnt = 16'd500;
        pulse_clr();
        mode_loop = 1'b1;

        // drive-fail
        tach_cnt = 16'd300;
        drive = 8'hFF;
        pulse_upd();
        pulse_upd();
        check("R6 two strobes not enough", int'(dfail_flag), 0);
        drive = 8'h80;
        pulse_upd();
        drive = 8'hFF;
        pulse_upd();
        pulse_upd();
        check("R6 run reset by partial drive", int'(dfail_flag), 0);
        pulse_upd();
        check("R6 third strobe trips", int'(dfail_flag), 1);
        check("R7 alert on drive-fail", int'(alert_n), 0);
        tach_cnt = 16'd240;
        pulse_clr();
        check("R8 clear drops drive-fail", int'(dfail_flag), 0);
        for (int i = 0; i < 4; i++) pulse_upd();
        check("R6 inside band no trip", int'(dfail_flag), 0);
        check("R7 alert idle", int'(alert_n), 1);

        step(3);
        report();
        $finish;
    end

endmodule